// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair with Trigger Selection

This block joins two eight-input interrupt controllers into one sixteen-line interrupt source. Lines 0 to 7 belong to the first controller, the primary. Lines 8 to 15 belong to the second controller, the secondary. The secondary feeds primary input 2, so the external line 2 is not used. Every line passes through a two-stage synchronizer. The block then compares the synchronized level with the level from the previous cycle, which gives a rising edge and a falling edge for each line.

A per-line trigger bit selects edge or level behaviour. The bits sit in two 8-bit trigger registers, one for each controller. Some bit positions cannot be set, so those lines always work as edge-triggered.

When a controller has a pending request that it has not yet signalled, it raises a flag. The secondary's flag produces a one-cycle set on primary input 2. The primary's flag drives the interrupt output.

The processor acknowledges with a one-cycle request. One cycle later the block returns an 8-bit vector, which is the chosen controller's 5-bit base followed by the 3-bit pin. Both controllers run with automatic end of interrupt and fixed priority, where pin 0 is the highest.

Top module: `irq_cascade_pair`

## Requirements
- R1: A write to the primary trigger register (`trig_sel`=0) stores the written byte ANDed with 0xF8, so lines 0, 1 and 2 cannot become level-triggered. A read with `trig_sel`=0 returns the stored value.
- R2: A write to the secondary trigger register (`trig_sel`=1) stores the written byte ANDed with 0xDE, so lines 8 and 13 cannot become level-triggered. A read with `trig_sel`=1 returns the stored value.
- R3: A rising edge on a line sets that line's request bit, and `irq_out` then rises. An acknowledge returns the vector {primary base, pin} for a primary line.
- R4: A level-triggered line that is still high after its acknowledge stays requested. `irq_out` rises again, and the next acknowledge returns the same vector.
- R5: A falling edge clears the request of a level-triggered line, so a later acknowledge finds nothing for that line. An edge-triggered request stays latched after its input falls and is delivered at the next acknowledge.
- R6: While a controller's ready input is low, its requests are held at zero and its line activity is dropped. An edge seen during that time does not raise `irq_out` later.
- R7: When the secondary has an eligible request it raises its flag and sets primary request 2. The acknowledge then returns {secondary base, secondary pin}, and both the secondary pin and primary pin 2 are accepted.
- R8: If nothing is eligible at acknowledge time, pin 7 is used. This gives {primary base, 7}, or {secondary base, 7} when the primary's choice was pin 2.
- R9: The external input `irq_in[2]` has no effect, because primary input 2 carries only the cascade.
- R10: An acknowledge clears the primary's raised flag. With nothing else pending, `irq_out` stays low after the acknowledge.
- R11: Lower pin numbers take priority. Primary lines 0 and 1 come before any secondary line, and any secondary line comes before primary lines 3 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_ready | input | 2 | Initialization complete: bit 0 primary, bit 1 secondary |
| pri_base | input | 5 | Upper five vector bits for the primary |
| sec_base | input | 5 | Upper five vector bits for the secondary |
| irq_in | input | 16 | Interrupt lines; bits 7:0 primary, bits 15:8 secondary |
| trig_wr | input | 1 | Trigger register write strobe |
| trig_sel | input | 1 | Trigger register select: 0 primary, 1 secondary |
| trig_wdata | input | 8 | Trigger register write data, 1 means level-triggered |
| trig_rdata | output | 8 | Selected trigger register contents |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_req | input | 1 | One-cycle acknowledge request |
| ack_valid | output | 1 | Vector valid, one cycle after `ack_req` |
| ack_vec | output | 8 | Acknowledge vector |

## Verification
The hardest situation to reach is a spurious vector that comes from the secondary. It needs a secondary request that existed long enough to set primary input 2 and then vanished before the acknowledge. The stimulus gets there by holding a level-triggered secondary line high for three cycles and then releasing it. The secondary's request clears on the falling edge, while the cascade request on the primary stays latched.

A sweep pulses each of the sixteen lines in turn. The bench derives the expected vector and the state of `irq_out` from the line number and the trigger masks. Held-level lines, competing pairs and an exhaustive sweep of trigger write values cover the remaining requirements.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
  localparam int unsigned LINES       = 8;
  localparam int unsigned PIN_W       = $clog2(LINES);
  localparam int unsigned BASE_W      = 5;
  localparam int unsigned VEC_W       = BASE_W + PIN_W;
  localparam int unsigned CASCADE_PIN = 2;
  localparam logic [LINES-1:0] PRI_TRIG_KEEP = 8'hF8;
  localparam logic [LINES-1:0] SEC_TRIG_KEEP = 8'hDE;
  localparam logic [PIN_W-1:0] IDLE_PIN = PIN_W'(LINES - 1);
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage0_q;
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= '0;
      stage1_q <= '0;
    end else begin
      stage0_q <= d;
      stage1_q <= stage0_q;
    end
  end

  assign q = stage1_q;
endmodule

// File: rtl/irq_trig_regs.sv
module irq_trig_regs
  import irq_pair_pkg::*;
#(
  parameter logic [LINES-1:0] PRI_KEEP = PRI_TRIG_KEEP,
  parameter logic [LINES-1:0] SEC_KEEP = SEC_TRIG_KEEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] pri_trig,
  output logic [LINES-1:0] sec_trig,
  output logic [LINES-1:0] rdata
);
  logic [LINES-1:0] pri_q, pri_n;
  logic [LINES-1:0] sec_q, sec_n;
  logic             pri_en, sec_en;

  always_comb begin
    pri_en = wr && !sel;
    sec_en = wr && sel;
    pri_n  = wdata & PRI_KEEP;
    sec_n  = wdata & SEC_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      if (pri_en) pri_q <= pri_n;
      if (sec_en) sec_q <= sec_n;
    end
  end

  assign pri_trig = pri_q;
  assign sec_trig = sec_q;
  assign rdata    = sel ? sec_q : pri_q;

  p_pri_fixed_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_q & ~PRI_KEEP) == '0);
  p_sec_fixed_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q & ~SEC_KEEP) == '0);
  p_pri_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && !sel) |=> $stable(pri_q));
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [LINES-1:0] lvl,
  input  logic [LINES-1:0] trig,
  input  logic [LINES-1:0] pulse_set,
  input  logic             acc_en,
  input  logic [PIN_W-1:0] acc_pin,
  output logic [LINES-1:0] req,
  output logic             elig,
  output logic [PIN_W-1:0] top_pin,
  output logic             raise_now,
  output logic             raised
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] req_q, req_n;
  logic [LINES-1:0] rise, fall;
  logic             raised_q, raised_n;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    always_comb begin
      req_n[gi] = req_q[gi];
      if (acc_en && (acc_pin == PIN_W'(gi)) && !lvl[gi]) req_n[gi] = 1'b0;
      if (fall[gi] && trig[gi]) req_n[gi] = 1'b0;
      if (rise[gi] || (lvl[gi] && trig[gi]) || pulse_set[gi]) req_n[gi] = 1'b1;
      if (!ready) req_n[gi] = 1'b0;
    end
  end

  always_comb begin
    top_pin = IDLE_PIN;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req_q[i]) top_pin = PIN_W'(i);
    end
    elig      = |req_q;
    raise_now = ready && elig && !raised_q;
    if (!ready)         raised_n = 1'b0;
    else if (acc_en)    raised_n = 1'b0;
    else if (raise_now) raised_n = 1'b1;
    else                raised_n = raised_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      req_q    <= '0;
      raised_q <= 1'b0;
    end else begin
      prev_q   <= lvl;
      req_q    <= req_n;
      raised_q <= raised_n;
    end
  end

  assign req    = req_q;
  assign raised = raised_q;

  p_not_ready_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (req_q == '0) && !raised_q);
  p_raise_needs_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raised_q) |-> $past(elig));
  p_ack_drops_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> !raised_q);
endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair
  import irq_pair_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ctl_ready,
  input  logic [BASE_W-1:0]   pri_base,
  input  logic [BASE_W-1:0]   sec_base,
  input  logic [2*LINES-1:0]  irq_in,
  input  logic                trig_wr,
  input  logic                trig_sel,
  input  logic [LINES-1:0]    trig_wdata,
  output logic [LINES-1:0]    trig_rdata,
  output logic                irq_out,
  input  logic                ack_req,
  output logic                ack_valid,
  output logic [VEC_W-1:0]    ack_vec
);
  localparam logic [LINES-1:0] CASCADE_BIT = LINES'(1) << CASCADE_PIN;

  logic [2*LINES-1:0] sync_lvl;
  logic [LINES-1:0]   pri_trig, sec_trig;
  logic [LINES-1:0]   pri_lvl, sec_lvl;
  logic [LINES-1:0]   pri_req, sec_req;
  logic [LINES-1:0]   pri_pulse;
  logic               pri_elig, sec_elig;
  logic [PIN_W-1:0]   pri_top, sec_top;
  logic               pri_raise, sec_raise;
  logic               pri_raised, sec_raised;
  logic               pick_sec;
  logic [VEC_W-1:0]   vec_n;
  logic               to_sec;
  logic               sec_acc_en;
  logic [PIN_W-1:0]   pri_acc_pin;
  logic [VEC_W-1:0]   vec_q;
  logic               valid_q;

  irq_sync #(.W(2*LINES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (irq_in), .q (sync_lvl)
  );

  irq_trig_regs u_trig (
    .clk (clk), .rst_n (rst_n), .wr (trig_wr), .sel (trig_sel),
    .wdata (trig_wdata), .pri_trig (pri_trig), .sec_trig (sec_trig),
    .rdata (trig_rdata)
  );

  assign pri_lvl   = sync_lvl[LINES-1:0] & ~CASCADE_BIT;
  assign sec_lvl   = sync_lvl[2*LINES-1:LINES];
  assign pri_pulse = sec_raise ? CASCADE_BIT : '0;

  irq_ctrl_unit u_sec (
    .clk (clk), .rst_n (rst_n), .ready (ctl_ready[1]), .lvl (sec_lvl),
    .trig (sec_trig), .pulse_set ('0), .acc_en (sec_acc_en),
    .acc_pin (vec_n[PIN_W-1:0]), .req (sec_req), .elig (sec_elig),
    .top_pin (sec_top), .raise_now (sec_raise), .raised (sec_raised)
  );

  irq_ctrl_unit u_pri (
    .clk (clk), .rst_n (rst_n), .ready (ctl_ready[0]), .lvl (pri_lvl),
    .trig (pri_trig), .pulse_set (pri_pulse), .acc_en (ack_req),
    .acc_pin (pri_acc_pin), .req (pri_req), .elig (pri_elig),
    .top_pin (pri_top), .raise_now (pri_raise), .raised (pri_raised)
  );

  always_comb begin
    pick_sec = pri_elig && (pri_top == PIN_W'(CASCADE_PIN));
    if (pick_sec) vec_n = {sec_base, (sec_elig ? sec_top : IDLE_PIN)};
    else          vec_n = {pri_base, (pri_elig ? pri_top : IDLE_PIN)};
    to_sec      = (vec_n[VEC_W-1:PIN_W] == sec_base);
    sec_acc_en  = ack_req && to_sec;
    pri_acc_pin = to_sec ? PIN_W'(CASCADE_PIN) : vec_n[PIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ack_req;
      if (ack_req) vec_q <= vec_n;
    end
  end

  assign irq_out   = pri_raised;
  assign ack_valid = valid_q;
  assign ack_vec   = vec_q;

  p_ack_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);
  p_ack_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_valid);
  p_cascade_sets_pin2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_raised) && ctl_ready[0] |-> pri_req[CASCADE_PIN]);
  p_line2_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_raise && ctl_ready[0] && $past(ctl_ready[0]) |=>
      (pri_req[CASCADE_PIN] == 1'b0) || $past(pri_req[CASCADE_PIN]));
endmodule

// File: tb/irq_cascade_pair_bench.sv
module irq_cascade_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PB = 5'h01;
  localparam logic [4:0] SB = 5'h0E;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ctl_ready;
  logic [15:0] irq_in;
  logic        trig_wr, trig_sel;
  logic [7:0]  trig_wdata, trig_rdata;
  logic        irq_out, ack_req, ack_valid;
  logic [7:0]  ack_vec;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_pair u_irq_cascade_pair (
    .clk (clk), .rst_n (rst_n), .ctl_ready (ctl_ready),
    .pri_base (PB), .sec_base (SB), .irq_in (irq_in),
    .trig_wr (trig_wr), .trig_sel (trig_sel), .trig_wdata (trig_wdata),
    .trig_rdata (trig_rdata), .irq_out (irq_out), .ack_req (ack_req),
    .ack_valid (ack_valid), .ack_vec (ack_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic trig_write(input logic sel, input logic [7:0] d);
    trig_sel = sel; trig_wdata = d; trig_wr = 1'b1;
    @(negedge clk);
    trig_wr = 1'b0;
  endtask

  task automatic do_ack(input string req, input int exp_vec);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    chk({req, " ack_valid"}, int'(ack_valid), 1);
    chk({req, " vector"}, int'(ack_vec), exp_vec);
  endtask

  task automatic pulse_line(input int line);
    irq_in[line] = 1'b1;
    idle(3);
    irq_in[line] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_ready = 2'b00; irq_in = '0; trig_wr = 1'b0;
    trig_sel = 1'b0; trig_wdata = '0; ack_req = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset irq_out", int'(irq_out), 0);
    chk("reset ack_valid", int'(ack_valid), 0);
    chk("reset trig pri", int'(trig_rdata), 0);

    // R6: activity while not ready is dropped
    pulse_line(0);
    idle(8);
    chk("R6 irq_out while not ready", int'(irq_out), 0);
    ctl_ready = 2'b11;
    idle(8);
    chk("R6 irq_out after ready", int'(irq_out), 0);

    // R1, R2: exhaustive write sweep of both trigger registers
    for (int v = 0; v < 256; v++) begin
      trig_write(1'b0, 8'(v));
      chk("R1 primary trigger readback", int'(trig_rdata), v & 8'hF8);
      trig_write(1'b1, 8'(v));
      chk("R2 secondary trigger readback", int'(trig_rdata), v & 8'hDE);
    end
    trig_write(1'b0, 8'hFF);
    trig_write(1'b1, 8'hFF);

    // R3, R5, R7, R8, R9, R10: pulse each line in turn
    for (int line = 0; line < 16; line++) begin
      automatic int pin   = line % 8;
      automatic bit sec   = (line >= 8);
      automatic bit edge_ = sec ? !((8'hDE >> pin) & 1) : !((8'hF8 >> pin) & 1);
      automatic int exp_v;
      automatic int exp_irq;
      if (line == 2) begin
        exp_irq = 0; exp_v = PB * 8 + 7;        // R9 line ignored
      end else if (edge_) begin
        exp_irq = 1; exp_v = (sec ? SB : PB) * 8 + pin;  // R3, R5, R7
      end else begin
        exp_irq = 1; exp_v = (sec ? SB : PB) * 8 + 7;    // R5 level dropped, R8
      end
      pulse_line(line);
      idle(8);
      chk($sformatf("R3 irq_out after line %0d", line), int'(irq_out), exp_irq);
      do_ack($sformatf("R8 line %0d", line), exp_v);
      idle(4);
      chk($sformatf("R10 irq_out after ack line %0d", line), int'(irq_out), 0);
    end

    // R8: acknowledge with nothing pending
    do_ack("R8 idle spurious", PB * 8 + 7);

    // R11: primary line 1 against secondary line 8
    irq_in[1] = 1'b1; irq_in[8] = 1'b1;
    idle(3);
    irq_in[1] = 1'b0; irq_in[8] = 1'b0;
    idle(8);
    do_ack("R11 line1 first", PB * 8 + 1);
    idle(4);
    chk("R11 irq_out for cascade", int'(irq_out), 1);
    do_ack("R11 line8 second", SB * 8 + 0);
    idle(4);
    chk("R10 irq_out after pair", int'(irq_out), 0);

    // R11: primary line 0 against secondary line 13
    irq_in[0] = 1'b1; irq_in[13] = 1'b1;
    idle(3);
    irq_in[0] = 1'b0; irq_in[13] = 1'b0;
    idle(8);
    do_ack("R11 line0 first", PB * 8 + 0);
    idle(4);
    do_ack("R7 line13 second", SB * 8 + 5);
    idle(4);

    // R11, R4: held level line 3 against secondary line 8
    irq_in[3] = 1'b1; irq_in[8] = 1'b1;
    idle(3);
    irq_in[8] = 1'b0;
    idle(8);
    do_ack("R11 cascade before line3", SB * 8 + 0);
    idle(4);
    do_ack("R4 line3 held", PB * 8 + 3);
    idle(6);
    chk("R4 irq_out re-raised", int'(irq_out), 1);
    do_ack("R4 line3 again", PB * 8 + 3);
    irq_in[3] = 1'b0;
    idle(8);
    do_ack("R5 line3 released", PB * 8 + 7);
    idle(4);
    chk("R10 irq_out final", int'(irq_out), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule